// File: doc/BRIEF.md
# Management-Bus PHY Address Scanner

This block searches the management bus for an attached PHY after reset. A pulse on the start input begins the search. The block waits a fixed interval so that a slow PHY has time to come out of reset. It then walks every PHY address in ascending order and reads the second identifier register (register 3) at each one. A read of 0xFFFF means the address is empty. Any other value means a device answered. The block then reads the first identifier register (register 2) at the same address and stops.

If a whole sweep finds nothing, the block waits again and repeats the sweep, up to a parameterised number of passes. The block talks to an MDIO master through a plain request/response port. It raises a request strobe with an address and a register number, then waits for the response strobe and its 16-bit data before it issues anything else. When the search ends, the block pulses done once and presents three results: a found flag, the address, and the 32-bit identifier. The identifier holds register 2 in its upper half and register 3 in its lower half. If no PHY was found, the address reads as all ones, which stands for "no PHY", and the identifier reads as zero.

Top module: `mdio_phy_scan`

## Requirements
- R1: After a synchronous active-high reset, done_o, found_o and mgmt_req_o are low, phy_addr_o is all ones and phy_id_o is zero.
- R2: start_i is accepted only while the block is idle. A start pulse during a search neither restarts the search nor queues a second one.
- R3: At least WAIT_CYCLES clock cycles, and at most WAIT_CYCLES+3, pass between an accepted start (or the last response of a failed sweep) and the first request of the next sweep.
- R4: A sweep probes addresses 0 up to 2^ADDR_W-1 in ascending order. Every probe first reads register ID_LO_REG (3). mgmt_reg_o carries only ID_LO_REG or ID_HI_REG (2).
- R5: A register-3 response of 0xFFFF moves the sweep to the next address. Any other value, 0xFFFE included, is followed by a register-2 read at the same address.
- R6: After the register-2 response, the block pulses done_o with found_o high, phy_addr_o set to that address and phy_id_o = {register-2 data, register-3 data}. No further request is issued.
- R7: The block runs at most MAX_PASSES sweeps, so a fruitless search issues exactly MAX_PASSES*2^ADDR_W requests. It then pulses done_o with found_o low, phy_addr_o all ones and phy_id_o zero.
- R8: mgmt_req_o is a one-cycle strobe. A new request is issued only after mgmt_rsp_valid_i has answered the previous one.
- R9: done_o is high for exactly one cycle per accepted start.
- R10: The results stay stable from done_o until the next accepted start. An accepted start clears them to the not-found values.
- R11: A PHY that first answers during a later sweep is found in that sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a search (accepted only when idle) |
| mgmt_req_o | output | 1 | One-cycle read request strobe to the management master |
| mgmt_phy_o | output | ADDR_W | PHY address of the request |
| mgmt_reg_o | output | REG_W | Register number of the request |
| mgmt_rsp_valid_i | input | 1 | Response strobe from the management master |
| mgmt_rsp_data_i | input | DATA_W | Data read from the PHY register |
| done_o | output | 1 | One-cycle pulse when the search ends |
| found_o | output | 1 | A PHY was found |
| phy_addr_o | output | ADDR_W | Address of the PHY found, all ones if none |
| phy_id_o | output | 2*DATA_W | Combined identifier {reg 2, reg 3}, zero if none |

## Verification
The bench builds the block with WAIT_CYCLES = 20 and MAX_PASSES = 3, keeping the 32-address sweep. These values make the inter-pass wait exactly measurable. They also let a complete three-pass failed search of 96 requests and a PHY that wakes only in the third pass run in a few hundred cycles. The responder model answers with a two-cycle latency. This exposes any request issued while a read is still pending, and it leaves room to inject start pulses mid-search.

// File: rtl/mdio_scan_pkg.sv
package mdio_scan_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_ASK_LO,
        ST_GET_LO,
        ST_ASK_HI,
        ST_GET_HI
    } scan_state_e;
endpackage

// File: rtl/scan_delay.sv
module scan_delay #(
    parameter int WAIT_CYCLES = 1000000
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    output logic expired_o
);
    localparam int CW = $clog2(WAIT_CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = CW'(WAIT_CYCLES);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/scan_cursor.sv
module scan_cursor #(
    parameter int ADDR_W     = 5,
    parameter int MAX_PASSES = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              last_addr_o,
    output logic              last_pass_o
);
    localparam int PW = (MAX_PASSES > 1) ? $clog2(MAX_PASSES) : 1;

    logic [ADDR_W-1:0] addr_d, addr_q;
    logic [PW-1:0]     pass_d, pass_q;

    assign last_addr_o = (addr_q == {ADDR_W{1'b1}});
    assign last_pass_o = (pass_q == PW'(MAX_PASSES - 1));

    always_comb begin
        addr_d = addr_q;
        pass_d = pass_q;
        if (clear_i) begin
            addr_d = '0;
            pass_d = '0;
        end else if (step_i) begin
            addr_d = addr_q + 1'b1;
            if (last_addr_o)
                pass_d = pass_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            pass_q <= '0;
        end else begin
            addr_q <= addr_d;
            pass_q <= pass_d;
        end
    end

    assign addr_o = addr_q;
endmodule

// File: rtl/mdio_phy_scan.sv
module mdio_phy_scan
    import mdio_scan_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int REG_W       = 5,
    parameter int DATA_W      = 16,
    parameter int WAIT_CYCLES = 1000000,
    parameter int MAX_PASSES  = 11,
    parameter int ID_HI_REG   = 2,
    parameter int ID_LO_REG   = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    output logic                mgmt_req_o,
    output logic [ADDR_W-1:0]   mgmt_phy_o,
    output logic [REG_W-1:0]    mgmt_reg_o,
    input  logic                mgmt_rsp_valid_i,
    input  logic [DATA_W-1:0]   mgmt_rsp_data_i,
    output logic                done_o,
    output logic                found_o,
    output logic [ADDR_W-1:0]   phy_addr_o,
    output logic [2*DATA_W-1:0] phy_id_o
);
    localparam int                ID_W      = 2 * DATA_W;
    localparam logic [ADDR_W-1:0] NONE_ADDR = {ADDR_W{1'b1}};
    localparam logic [DATA_W-1:0] EMPTY_RD  = {DATA_W{1'b1}};

    typedef struct packed {
        scan_state_e       state;
        logic [DATA_W-1:0] lo_data;
        logic              done;
        logic              found;
        logic [ADDR_W-1:0] addr;
        logic [ID_W-1:0]   id;
    } scan_regs_t;

    scan_regs_t r_d, r_q;

    logic              cur_clear, cur_step, dly_load;
    logic              dly_expired, last_addr, last_pass;
    logic [ADDR_W-1:0] cur_addr;

    scan_delay #(.WAIT_CYCLES(WAIT_CYCLES)) u_delay (
        .clk       (clk),
        .rst       (rst),
        .load_i    (dly_load),
        .expired_o (dly_expired)
    );

    scan_cursor #(.ADDR_W(ADDR_W), .MAX_PASSES(MAX_PASSES)) u_cursor (
        .clk         (clk),
        .rst         (rst),
        .clear_i     (cur_clear),
        .step_i      (cur_step),
        .addr_o      (cur_addr),
        .last_addr_o (last_addr),
        .last_pass_o (last_pass)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        cur_clear = 1'b0;
        cur_step  = 1'b0;
        dly_load  = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    cur_clear = 1'b1;
                    dly_load  = 1'b1;
                    r_d.found = 1'b0;
                    r_d.addr  = NONE_ADDR;
                    r_d.id    = '0;
                    r_d.state = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (dly_expired)
                    r_d.state = ST_ASK_LO;
            end
            ST_ASK_LO: r_d.state = ST_GET_LO;
            ST_GET_LO: begin
                if (mgmt_rsp_valid_i) begin
                    if (mgmt_rsp_data_i != EMPTY_RD) begin
                        r_d.lo_data = mgmt_rsp_data_i;
                        r_d.state   = ST_ASK_HI;
                    end else if (last_addr && last_pass) begin
                        r_d.done  = 1'b1;
                        r_d.state = ST_IDLE;
                    end else begin
                        cur_step = 1'b1;
                        if (last_addr) begin
                            dly_load  = 1'b1;
                            r_d.state = ST_WAIT;
                        end else begin
                            r_d.state = ST_ASK_LO;
                        end
                    end
                end
            end
            ST_ASK_HI: r_d.state = ST_GET_HI;
            ST_GET_HI: begin
                if (mgmt_rsp_valid_i) begin
                    r_d.found = 1'b1;
                    r_d.addr  = cur_addr;
                    r_d.id    = {mgmt_rsp_data_i, r_q.lo_data};
                    r_d.done  = 1'b1;
                    r_d.state = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.state   <= ST_IDLE;
            r_q.lo_data <= '0;
            r_q.done    <= 1'b0;
            r_q.found   <= 1'b0;
            r_q.addr    <= NONE_ADDR;
            r_q.id      <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mgmt_req_o = (r_q.state == ST_ASK_LO) || (r_q.state == ST_ASK_HI);
    assign mgmt_phy_o = cur_addr;
    assign mgmt_reg_o = (r_q.state == ST_ASK_HI) ? REG_W'(ID_HI_REG) : REG_W'(ID_LO_REG);
    assign done_o     = r_q.done;
    assign found_o    = r_q.found;
    assign phy_addr_o = r_q.addr;
    assign phy_id_o   = r_q.id;
endmodule

// File: rtl/mdio_phy_scan_chk.sv
module mdio_phy_scan_chk #(
    parameter int ADDR_W    = 5,
    parameter int REG_W     = 5,
    parameter int DATA_W    = 16,
    parameter int ID_HI_REG = 2,
    parameter int ID_LO_REG = 3
) (
    input logic                clk,
    input logic                rst,
    input logic                mgmt_req_o,
    input logic [ADDR_W-1:0]   mgmt_phy_o,
    input logic [REG_W-1:0]    mgmt_reg_o,
    input logic                mgmt_rsp_valid_i,
    input logic                done_o,
    input logic                found_o,
    input logic [ADDR_W-1:0]   phy_addr_o,
    input logic [2*DATA_W-1:0] phy_id_o
);
    localparam logic [REG_W-1:0] HI = REG_W'(ID_HI_REG);
    localparam logic [REG_W-1:0] LO = REG_W'(ID_LO_REG);

    logic              pending_q, prev_valid_q;
    logic [REG_W-1:0]  prev_reg_q;
    logic [ADDR_W-1:0] prev_phy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q    <= 1'b0;
            prev_valid_q <= 1'b0;
            prev_reg_q   <= '0;
            prev_phy_q   <= '0;
        end else begin
            if (mgmt_req_o) begin
                pending_q    <= 1'b1;
                prev_valid_q <= 1'b1;
                prev_reg_q   <= mgmt_reg_o;
                prev_phy_q   <= mgmt_phy_o;
            end else if (mgmt_rsp_valid_i) begin
                pending_q <= 1'b0;
            end
        end
    end

    AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        mgmt_req_o |-> !pending_q); // R8
    AST_REQ_STROBE: assert property (@(posedge clk) disable iff (rst)
        mgmt_req_o |=> !mgmt_req_o); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R9
    AST_REQ_REG_LEGAL: assert property (@(posedge clk) disable iff (rst)
        mgmt_req_o |-> (mgmt_reg_o == HI || mgmt_reg_o == LO)); // R4
    AST_ADDR_ASCEND: assert property (@(posedge clk) disable iff (rst)
        (mgmt_req_o && mgmt_reg_o == LO && prev_valid_q && prev_reg_q == LO)
        |-> (mgmt_phy_o == ADDR_W'(prev_phy_q + 1'b1))); // R4
    AST_HI_FOLLOWS_LO: assert property (@(posedge clk) disable iff (rst)
        (mgmt_req_o && mgmt_reg_o == HI)
        |-> (prev_valid_q && prev_reg_q == LO && prev_phy_q == mgmt_phy_o)); // R5
    AST_FOUND_ID_VALID: assert property (@(posedge clk) disable iff (rst)
        (done_o && found_o) |-> (phy_id_o[DATA_W-1:0] != {DATA_W{1'b1}})); // R6
    AST_NOTFOUND_OUT: assert property (@(posedge clk) disable iff (rst)
        (done_o && !found_o) |-> (phy_addr_o == {ADDR_W{1'b1}} && phy_id_o == '0)); // R7
endmodule

bind mdio_phy_scan mdio_phy_scan_chk #(
    .ADDR_W(ADDR_W), .REG_W(REG_W), .DATA_W(DATA_W),
    .ID_HI_REG(ID_HI_REG), .ID_LO_REG(ID_LO_REG)
) u_chk (
    .clk              (clk),
    .rst              (rst),
    .mgmt_req_o       (mgmt_req_o),
    .mgmt_phy_o       (mgmt_phy_o),
    .mgmt_reg_o       (mgmt_reg_o),
    .mgmt_rsp_valid_i (mgmt_rsp_valid_i),
    .done_o           (done_o),
    .found_o          (found_o),
    .phy_addr_o       (phy_addr_o),
    .phy_id_o         (phy_id_o)
);

// File: tb/mdio_phy_scan_tb.sv
module mdio_phy_scan_tb;
    localparam int W   = 20;
    localparam int P   = 3;
    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        mgmt_req_o;
    logic [4:0]  mgmt_phy_o;
    logic [4:0]  mgmt_reg_o;
    logic        mgmt_rsp_valid_i = 1'b0;
    logic [15:0] mgmt_rsp_data_i = '0;
    logic        done_o, found_o;
    logic [4:0]  phy_addr_o;
    logic [31:0] phy_id_o;

    mdio_phy_scan #(.WAIT_CYCLES(W), .MAX_PASSES(P)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i),
        .mgmt_req_o(mgmt_req_o), .mgmt_phy_o(mgmt_phy_o), .mgmt_reg_o(mgmt_reg_o),
        .mgmt_rsp_valid_i(mgmt_rsp_valid_i), .mgmt_rsp_data_i(mgmt_rsp_data_i),
        .done_o(done_o), .found_o(found_o), .phy_addr_o(phy_addr_o), .phy_id_o(phy_id_o)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int total = 0, fails = 0;
    int nreq = 0, ndone = 0, pass_seen = 0;
    int ord_err = 0, ovl_err = 0;
    int start_cyc = 0, first_req_cyc = 0;
    logic [15:0] lo_tab [32];
    logic [15:0] hi_tab [32];
    int          wake_tab [32];
    logic       have_prev = 1'b0;
    logic [4:0] prev_phy = '0;
    logic [4:0] prev_reg = '0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // responder model of the management master
    initial begin
        forever begin
            @(negedge clk);
            mgmt_rsp_valid_i = 1'b0;
            if (mgmt_req_o) begin
                logic [4:0]  ph;
                logic [4:0]  rg;
                logic [15:0] dat;
                ph = mgmt_phy_o;
                rg = mgmt_reg_o;
                nreq++;
                if (nreq == 1) first_req_cyc = cyc;
                if (rg == 5'd3 && ph == 5'd0) pass_seen++;
                if (rg == 5'd3 && have_prev && prev_reg == 5'd3 && ph != prev_phy + 5'd1) ord_err++;
                if (rg == 5'd2 && !(have_prev && prev_reg == 5'd3 && prev_phy == ph)) ord_err++;
                if (rg != 5'd2 && rg != 5'd3) ord_err++;
                have_prev = 1'b1;
                prev_phy  = ph;
                prev_reg  = rg;
                if (rg == 5'd3)
                    dat = (wake_tab[ph] != 0 && pass_seen >= wake_tab[ph]) ? lo_tab[ph] : 16'hFFFF;
                else
                    dat = hi_tab[ph];
                for (int k = 0; k < LAT; k++) begin
                    @(negedge clk);
                    if (mgmt_req_o) ovl_err++;
                end
                mgmt_rsp_valid_i = 1'b1;
                mgmt_rsp_data_i  = dat;
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (done_o) ndone++;
        end
    end

    task automatic clear_tabs();
        for (int i = 0; i < 32; i++) begin
            wake_tab[i] = 0;
            lo_tab[i]   = 16'hFFFF;
            hi_tab[i]   = 16'hFFFF;
        end
    endtask

    task automatic do_start();
        @(negedge clk);
        nreq = 0; pass_seen = 0; ord_err = 0; ovl_err = 0;
        start_cyc = cyc;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic finish_search(input string tag, input logic ef, input logic [4:0] ea,
                                 input logic [31:0] eid, input int en, input int d0);
        int n_at_done;
        wait (ndone >= d0 + 1);
        @(negedge clk);
        chk({tag, " R6/R7 found"}, found_o, ef);
        chk({tag, " R6/R7 addr"}, phy_addr_o, ea);
        chk({tag, " R6/R7 id"}, phy_id_o, eid);
        chk({tag, " R4/R5 request count"}, nreq, en);
        chk({tag, " R4/R5 ordering errors"}, ord_err, 0);
        chk({tag, " R8 overlap errors"}, ovl_err, 0);
        chk({tag, " R3 first wait"}, (first_req_cyc - start_cyc >= W) && (first_req_cyc - start_cyc <= W + 3), 1);
        n_at_done = nreq;
        repeat (12) @(negedge clk);
        chk({tag, " R6 no request after done"}, nreq, n_at_done);
        chk({tag, " R9 single done"}, ndone, d0 + 1);
        chk({tag, " R10 results hold"}, {found_o, phy_addr_o, phy_id_o}, {ef, ea, eid});
    endtask

    task automatic t_reset();
        chk("R1 done", done_o, 0);
        chk("R1 found", found_o, 0);
        chk("R1 addr", phy_addr_o, 5'h1F);
        chk("R1 id", phy_id_o, 0);
        chk("R1 req", mgmt_req_o, 0);
    endtask

    task automatic t_mid_addr();
        int d0;
        clear_tabs();
        wake_tab[5] = 1; lo_tab[5] = 16'h1561; hi_tab[5] = 16'h0022;
        d0 = ndone;
        do_start();
        finish_search("mid addr", 1'b1, 5'd5, 32'h0022_1561, 7, d0);
    endtask

    task automatic t_addr0_fffe();
        int d0;
        clear_tabs();
        wake_tab[0] = 1; lo_tab[0] = 16'hFFFE; hi_tab[0] = 16'h0181;
        wake_tab[9] = 1; lo_tab[9] = 16'hB880; hi_tab[9] = 16'h0181;
        d0 = ndone;
        do_start();
        chk("R10 cleared at start found", found_o, 0);
        chk("R10 cleared at start addr", phy_addr_o, 5'h1F);
        finish_search("addr0 fffe R5", 1'b1, 5'd0, 32'h0181_FFFE, 2, d0);
    endtask

    task automatic t_addr31();
        int d0;
        clear_tabs();
        wake_tab[31] = 1; lo_tab[31] = 16'h5610; hi_tab[31] = 16'h0000;
        d0 = ndone;
        do_start();
        finish_search("addr31", 1'b1, 5'd31, 32'h0000_5610, 33, d0);
    endtask

    task automatic t_none();
        int d0;
        clear_tabs();
        d0 = ndone;
        do_start();
        finish_search("none R7", 1'b0, 5'h1F, 32'h0, P * 32, d0);
        chk("R7 pass count", pass_seen, P);
    endtask

    task automatic t_late_wake();
        int d0;
        clear_tabs();
        wake_tab[7] = 3; lo_tab[7] = 16'h78E0; hi_tab[7] = 16'h0013;
        d0 = ndone;
        do_start();
        finish_search("late wake R11", 1'b1, 5'd7, 32'h0013_78E0, 64 + 8 + 1, d0);
        chk("R11 found in pass", pass_seen, 3);
    endtask

    task automatic t_busy_start();
        int d0;
        clear_tabs();
        wake_tab[5] = 1; lo_tab[5] = 16'h1561; hi_tab[5] = 16'h0022;
        d0 = ndone;
        do_start();
        repeat (4) @(negedge clk);
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        wait (nreq == 3);
        @(negedge clk);
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        finish_search("busy start R2", 1'b1, 5'd5, 32'h0022_1561, 7, d0);
        repeat (W + 10) @(negedge clk);
        chk("R2 no queued search", nreq, 7);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        clear_tabs();
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        repeat (2) @(negedge clk);
        t_reset();
        t_mid_addr();
        t_addr0_fffe();
        t_addr31();
        t_none();
        t_late_wake();
        t_busy_start();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule